// File: doc/BRIEF.md
# PCI Target Back-End Decoder and Burst Register File

This block sits on the user side of a PCI target core. In the address cycle of each access the core drives the address onto its shared address/data bus and the bus command onto its shared command/byte-enable bus, and it flags that cycle with an address-valid strobe. The block decodes the command into user-read and user-write requests. It compares the address against one base address window to produce a select. It also takes a private copy of the address, because the core shows the address only in that first cycle.

After the address cycle the core pulses an increment strobe once for each data phase that completes. The block adds one DWORD (four bytes) to its local burst address on each pulse. In a write, every increment-strobe cycle carries a DWORD that must be stored, and the byte enables (active low) choose which byte lanes change. In a read, the pulse means the previous DWORD has left on the bus, so the next DWORD is fetched through a registered read port. Configuration writes raise their own strobe and never reach the register file.

Top module: `pci_tgt_backend`

## Requirements
- R1: `rd_decode_o` is high exactly when `adr_valid_i` is high and `cbe_i` holds a read command: 4'b0010 (I/O read), 4'b0110 (memory read), 4'b1100 (memory read multiple) or 4'b1110 (memory read line).
- R2: `wr_decode_o` is high exactly when `adr_valid_i` is high and `cbe_i` holds a write command: 4'b0011 (I/O write), 4'b0111 (memory write) or 4'b1111 (memory write and invalidate).
- R3: `select_o` is high exactly when `adr_valid_i` is high, `ad_i` and `bar_base_i` agree in bits [31:WIN_BITS], and the space enable is set: `space_en_i[1]` for a memory window (BAR_IO=0) or `space_en_i[0]` for an I/O window.
- R4: On the clock edge that follows an address-valid cycle, `burst_addr_o` equals `ad_i` of that cycle with bits [1:0] cleared.
- R5: After a cycle with `adr_inc_i` high and `adr_valid_i` low, `burst_addr_o` has risen by 4. After a cycle with both strobes low, it is unchanged.
- R6: `usr_wr_stb_o` equals `usr_write_i` AND `adr_inc_i`, and `cfg_wr_stb_o` equals `cfg_write_i` AND `adr_inc_i`, in the same cycle.
- R7: On a user write strobe the word at `burst_addr_o` takes `ad_i` only in the byte lanes whose `cbe_i` bit is 0 (lane n is bits [8n+7:8n]). `wr_lane_o` shows the inverted enables. The write does not depend on any ready condition.
- R8: One cycle after an address-valid cycle or an increment cycle, `rd_data_o` holds the stored word at the new `burst_addr_o`.
- R9: The register-file word index is `burst_addr_o[WIN_BITS-1:2]`. A burst that runs past the top of the window wraps to word 0.
- R10: While reset is applied, `burst_addr_o` and `rd_data_o` are zero.
- R11: A configuration write strobe leaves every register-file word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address in the address cycle, write data in data cycles |
| cbe_i | input | 4 | Command in the address cycle, active-low byte enables in data cycles |
| adr_valid_i | input | 1 | Address cycle of an access |
| adr_inc_i | input | 1 | A data phase completed |
| usr_write_i | input | 1 | User write access in progress |
| cfg_write_i | input | 1 | Configuration write access in progress |
| bar_base_i | input | 32 | Base address of the window |
| space_en_i | input | 2 | Bit 1 memory-space enable, bit 0 I/O-space enable |
| rd_decode_o | output | 1 | User read command decoded |
| wr_decode_o | output | 1 | User write command decoded |
| select_o | output | 1 | Address hits the enabled window |
| usr_wr_stb_o | output | 1 | Per-DWORD user write strobe |
| cfg_wr_stb_o | output | 1 | Per-DWORD configuration write strobe |
| wr_lane_o | output | 4 | Active-high byte lanes of the current write |
| wr_data_o | output | 32 | Write data of the current DWORD |
| burst_addr_o | output | 32 | Local burst byte address |
| rd_data_o | output | 32 | Registered read data |

## Verification
The bench builds the block with WIN_BITS=6, which gives a 64-byte window of 16 words. With so few words, random bursts often run past the top word and wrap to word 0, and they often read back data written by earlier bursts. The small window also brings the edges of the select range within reach: the first and last byte inside the window and the bytes just outside it. The default BAR_IO=0 is kept, so the memory-space enable bit is the one that gates the select.

// File: rtl/pci_be_pkg.sv
package pci_be_pkg;

  typedef logic [3:0] cmd_t;

  localparam cmd_t CMD_IO_RD   = 4'b0010;
  localparam cmd_t CMD_IO_WR   = 4'b0011;
  localparam cmd_t CMD_MEM_RD  = 4'b0110;
  localparam cmd_t CMD_MEM_WR  = 4'b0111;
  localparam cmd_t CMD_MEM_RDM = 4'b1100;
  localparam cmd_t CMD_MEM_RDL = 4'b1110;
  localparam cmd_t CMD_MEM_WRI = 4'b1111;

  function automatic logic is_rd_cmd(input cmd_t c);
    return (c == CMD_IO_RD) || (c == CMD_MEM_RD) ||
           (c == CMD_MEM_RDM) || (c == CMD_MEM_RDL);
  endfunction

  function automatic logic is_wr_cmd(input cmd_t c);
    return (c == CMD_IO_WR) || (c == CMD_MEM_WR) || (c == CMD_MEM_WRI);
  endfunction

endpackage

// File: rtl/pci_be_cmd_dec.sv
module pci_be_cmd_dec
  import pci_be_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 12,
  parameter bit BAR_IO   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adr_valid_i,
  input  cmd_t              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] bar_base_i,
  input  logic [1:0]        space_en_i,
  output logic              rd_dec_o,
  output logic              wr_dec_o,
  output logic              sel_o
);

  localparam logic [ADDR_W-1:0] HI_MASK = ~((ADDR_W'(1) << WIN_BITS) - ADDR_W'(1));

  logic win_hit;
  logic space_on;

  generate
    if (BAR_IO) begin : g_io_win
      assign space_on = space_en_i[0] | (space_en_i[1] & 1'b0);
    end else begin : g_mem_win
      assign space_on = space_en_i[1] | (space_en_i[0] & 1'b0);
    end
  endgenerate

  always_comb begin
    win_hit  = ((addr_i & HI_MASK) == (bar_base_i & HI_MASK));
    rd_dec_o = adr_valid_i & is_rd_cmd(cmd_i);
    wr_dec_o = adr_valid_i & is_wr_cmd(cmd_i);
    sel_o    = adr_valid_i & win_hit & space_on;
  end

  AST_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_dec_o && wr_dec_o)); // R1

  AST_SEL_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o |-> adr_valid_i); // R3

endmodule

// File: rtl/pci_be_addr_ctr.sv
module pci_be_addr_ctr #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adr_valid_i,
  input  logic              adr_inc_i,
  input  logic [WORD_W-1:0] addr_word_i,
  output logic [WORD_W-1:0] word_q_o,
  output logic [WORD_W-1:0] word_d_o
);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic              word_en;

  always_comb begin
    word_en = adr_valid_i | adr_inc_i;
    if (adr_valid_i) begin
      word_d = addr_word_i;
    end else if (adr_inc_i) begin
      word_d = word_q + WORD_W'(1);
    end else begin
      word_d = word_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign word_q_o = word_q;
  assign word_d_o = word_d;

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    adr_valid_i |=> (word_q == $past(addr_word_i))); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!adr_valid_i && adr_inc_i) |=> (word_q == $past(word_q) + WORD_W'(1))); // R5

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adr_valid_i && !adr_inc_i) |=> $stable(word_q)); // R5

endmodule

// File: rtl/pci_be_regfile.sv
module pci_be_regfile #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [DATA_W/8-1:0] lane_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [DATA_W-1:0]   rdata_o
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_i[l]) begin
          mem[wr_idx_i][8*l +: 8] <= wdata_i[8*l +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= mem[rd_idx_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/pci_tgt_backend.sv
module pci_tgt_backend
  import pci_be_pkg::*;
#(
  parameter int WIN_BITS = 12,
  parameter bit BAR_IO   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_i,
  input  logic        adr_valid_i,
  input  logic        adr_inc_i,
  input  logic        usr_write_i,
  input  logic        cfg_write_i,
  input  logic [31:0] bar_base_i,
  input  logic [1:0]  space_en_i,
  output logic        rd_decode_o,
  output logic        wr_decode_o,
  output logic        select_o,
  output logic        usr_wr_stb_o,
  output logic        cfg_wr_stb_o,
  output logic [3:0]  wr_lane_o,
  output logic [31:0] wr_data_o,
  output logic [31:0] burst_addr_o,
  output logic [31:0] rd_data_o
);

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WORD_W = ADDR_W - 2;
  localparam int IDX_W  = WIN_BITS - 2;

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic [3:0]        lane;
  logic              usr_stb;

  pci_be_cmd_dec #(
    .ADDR_W  (ADDR_W),
    .WIN_BITS(WIN_BITS),
    .BAR_IO  (BAR_IO)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .adr_valid_i(adr_valid_i),
    .cmd_i      (cbe_i),
    .addr_i     (ad_i),
    .bar_base_i (bar_base_i),
    .space_en_i (space_en_i),
    .rd_dec_o   (rd_decode_o),
    .wr_dec_o   (wr_decode_o),
    .sel_o      (select_o)
  );

  pci_be_addr_ctr #(
    .WORD_W(WORD_W)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .adr_valid_i(adr_valid_i),
    .adr_inc_i  (adr_inc_i),
    .addr_word_i(ad_i[ADDR_W-1:2]),
    .word_q_o   (word_q),
    .word_d_o   (word_d)
  );

  always_comb begin
    lane    = ~cbe_i;
    usr_stb = usr_write_i & adr_inc_i;
  end

  pci_be_regfile #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (usr_stb),
    .wr_idx_i(word_q[IDX_W-1:0]),
    .lane_i  (lane),
    .wdata_i (ad_i),
    .rd_idx_i(word_d[IDX_W-1:0]),
    .rdata_o (rd_data_o)
  );

  assign usr_wr_stb_o = usr_stb;
  assign cfg_wr_stb_o = cfg_write_i & adr_inc_i;
  assign wr_lane_o    = lane;
  assign wr_data_o    = ad_i;
  assign burst_addr_o = {word_q, 2'b00};

  AST_USR_STB_ON_INC: assert property (@(posedge clk) disable iff (!rst_n)
    usr_wr_stb_o |-> (adr_inc_i && usr_write_i)); // R6

  AST_CFG_STB_ON_INC: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_stb_o |-> (adr_inc_i && cfg_write_i)); // R6

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    burst_addr_o[1:0] == 2'b00); // R4

endmodule

// File: tb/pci_tgt_backend_tb.sv
module pci_tgt_backend_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 6;
  localparam int DEPTH      = 1 << (WIN - 2);

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ad_i;
  logic [3:0]  cbe_i;
  logic        adr_valid_i, adr_inc_i, usr_write_i, cfg_write_i;
  logic [31:0] bar_base_i;
  logic [1:0]  space_en_i;
  logic        rd_decode_o, wr_decode_o, select_o, usr_wr_stb_o, cfg_wr_stb_o;
  logic [3:0]  wr_lane_o;
  logic [31:0] wr_data_o, burst_addr_o, rd_data_o;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] mdl [DEPTH];
  int unsigned seed_dummy;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_tgt_backend #(.WIN_BITS(WIN), .BAR_IO(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
    .adr_valid_i(adr_valid_i), .adr_inc_i(adr_inc_i),
    .usr_write_i(usr_write_i), .cfg_write_i(cfg_write_i),
    .bar_base_i(bar_base_i), .space_en_i(space_en_i),
    .rd_decode_o(rd_decode_o), .wr_decode_o(wr_decode_o), .select_o(select_o),
    .usr_wr_stb_o(usr_wr_stb_o), .cfg_wr_stb_o(cfg_wr_stb_o),
    .wr_lane_o(wr_lane_o), .wr_data_o(wr_data_o),
    .burst_addr_o(burst_addr_o), .rd_data_o(rd_data_o)
  );

  function automatic logic exp_rd(input logic [3:0] c);
    return c == 4'b0010 || c == 4'b0110 || c == 4'b1100 || c == 4'b1110;
  endfunction

  function automatic logic exp_wr(input logic [3:0] c);
    return c == 4'b0011 || c == 4'b0111 || c == 4'b1111;
  endfunction

  function automatic logic exp_sel(input logic v, input logic [31:0] a,
                                   input logic [31:0] b, input logic [1:0] en);
    return v && ((a >> WIN) == (b >> WIN)) && en[1];
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be_n);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (!be_n[l]) r[8*l +: 8] = d[8*l +: 8];
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_drive();
    adr_valid_i = 0; adr_inc_i = 0; usr_write_i = 0; cfg_write_i = 0;
  endtask

  task automatic wr_burst(input logic [31:0] addr, input int n, input logic is_cfg,
                          input logic full_be, input string tag);
    logic [29:0] w = addr[31:2];
    @(negedge clk);
    idle_drive(); adr_valid_i = 1; ad_i = addr; cbe_i = is_cfg ? 4'b1011 : 4'b0111;
    #1;
    if (!is_cfg) chk(wr_decode_o == 1'b1, "R2", 32'(wr_decode_o), 32'd1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(burst_addr_o == {w, 2'b00}, k == 0 ? "R4" : "R5", burst_addr_o, {w, 2'b00});
      if ($urandom_range(3) == 0) begin
        idle_drive(); usr_write_i = !is_cfg; cfg_write_i = is_cfg;
        #1;
        chk(usr_wr_stb_o == 1'b0 && cfg_wr_stb_o == 1'b0, "R6",
            {usr_wr_stb_o, cfg_wr_stb_o}, 32'd0);
        @(negedge clk);
        chk(burst_addr_o == {w, 2'b00}, "R5", burst_addr_o, {w, 2'b00});
      end
      adr_valid_i = 0; adr_inc_i = 1; usr_write_i = !is_cfg; cfg_write_i = is_cfg;
      ad_i = $urandom; cbe_i = full_be ? 4'b0000 : 4'($urandom);
      #1;
      chk(usr_wr_stb_o == !is_cfg && cfg_wr_stb_o == is_cfg, "R6",
          {usr_wr_stb_o, cfg_wr_stb_o}, {!is_cfg, is_cfg});
      chk(wr_lane_o == ~cbe_i && wr_data_o == ad_i, "R7", {28'd0, wr_lane_o}, {28'd0, ~cbe_i});
      if (!is_cfg) mdl[w % DEPTH] = merge(mdl[w % DEPTH], ad_i, cbe_i);
      w = w + 1;
    end
    @(negedge clk);
    chk(burst_addr_o == {w, 2'b00}, tag, burst_addr_o, {w, 2'b00});
    idle_drive();
  endtask

  task automatic rd_burst(input logic [31:0] addr, input int n, input string tag);
    logic [29:0] w = addr[31:2];
    @(negedge clk);
    idle_drive(); adr_valid_i = 1; ad_i = addr; cbe_i = 4'b0110;
    #1;
    chk(rd_decode_o == 1'b1, "R1", 32'(rd_decode_o), 32'd1);
    @(negedge clk);
    chk(rd_data_o == mdl[w % DEPTH], tag, rd_data_o, mdl[w % DEPTH]);
    for (int k = 1; k < n; k++) begin
      adr_valid_i = 0; adr_inc_i = 1; ad_i = $urandom;
      @(negedge clk);
      w = w + 1;
      chk(rd_data_o == mdl[w % DEPTH], tag, rd_data_o, mdl[w % DEPTH]);
    end
    idle_drive();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    seed_dummy = $urandom(32'd7341);
    rst_n = 0; idle_drive(); ad_i = 0; cbe_i = 0;
    bar_base_i = 32'hA000_0040; space_en_i = 2'b10;
    repeat (3) @(negedge clk);
    chk(burst_addr_o == 0 && rd_data_o == 0, "R10", burst_addr_o | rd_data_o, 32'd0);
    rst_n = 1;

    // R1 R2: decode sweep with and without address-valid
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cbe_i = 4'(c); ad_i = 32'h0; adr_valid_i = 1;
      #1;
      chk(rd_decode_o == exp_rd(4'(c)), "R1", 32'(rd_decode_o), 32'(exp_rd(4'(c))));
      chk(wr_decode_o == exp_wr(4'(c)), "R2", 32'(wr_decode_o), 32'(exp_wr(4'(c))));
      adr_valid_i = 0;
      #1;
      chk(!rd_decode_o && !wr_decode_o, "R1", {rd_decode_o, wr_decode_o}, 32'd0);
    end

    // R3: directed window edges, enable bits, then random
    for (int t = 0; t < 40; t++) begin
      logic [31:0] a;
      @(negedge clk);
      case (t)
        0: a = 32'hA000_0040;
        1: a = 32'hA000_007F;
        2: a = 32'hA000_0080;
        3: a = 32'hA000_003F;
        default: a = (t % 2) ? (32'hA000_0040 | 32'($urandom_range(63))) : $urandom;
      endcase
      space_en_i = (t == 4) ? 2'b01 : ((t > 4) ? 2'($urandom) : 2'b10);
      adr_valid_i = (t < 6) ? 1'b1 : 1'($urandom);
      ad_i = a; cbe_i = 4'b0110;
      #1;
      chk(select_o == exp_sel(adr_valid_i, a, bar_base_i, space_en_i), "R3",
          32'(select_o), 32'(exp_sel(adr_valid_i, a, bar_base_i, space_en_i)));
    end
    idle_drive(); space_en_i = 2'b10;

    // fill the window, then read it back
    wr_burst(32'hA000_0040, DEPTH, 1'b0, 1'b1, "R5");
    rd_burst(32'hA000_0040, DEPTH, "R8");

    // R9: burst crossing the top of the window
    wr_burst(32'hA000_0040 + 32'((DEPTH - 2) * 4), 4, 1'b0, 1'b0, "R9");
    rd_burst(32'hA000_0040 + 32'((DEPTH - 3) * 4), 6, "R9");

    // R11: configuration write leaves storage alone
    wr_burst(32'hA000_0044, 5, 1'b1, 1'b1, "R11");
    rd_burst(32'hA000_0040, DEPTH, "R11");

    // R7: random lane writes mixed with reads
    for (int it = 0; it < 30; it++) begin
      logic [31:0] a = 32'hA000_0040 | (32'($urandom_range(DEPTH - 1)) << 2);
      if ($urandom_range(1)) wr_burst(a, $urandom_range(1, 6), 1'b0, 1'b0, "R5");
      else rd_burst(a, $urandom_range(1, 6), "R7");
    end
    rd_burst(32'hA000_0040, DEPTH, "R7");

    repeat (2) @(negedge clk);
    summary();
  end

endmodule